// File: doc/BRIEF.md
# Multicast Receive Mailbox with Shared Slots

This block is the receive half of a mailbox shared by the threads of one tile. A message arrives with a whole payload of several flits and a destination mask with one bit per thread. The block takes a free scratchpad slot and writes the payload there once. It then appends the slot number to the receive queue of every thread named in the mask. Any subset of threads can therefore read one stored copy, and the block never has to copy the payload.

Each slot has a reference count. When a message is stored, the count is loaded with the number of set bits in the mask. A thread dequeues a slot number to find its message. When it is done with the message it returns the slot number. The last release sends the slot back to the free list. The per-thread queues are grouped into banks, and each bank keeps its queue entries in one RAM. When a message is accepted, each bank walks its part of the mask and makes one enqueue per cycle. All banks do this at the same time.

Top module: `mbx_mcast_rx`

## Requirements
- R1: After reset the free list holds all 16 slots, every thread queue reads empty, `in_ready` is high, `sp_we` is low and `rx_resp_valid` is low.
- R2: A message with a nonzero mask is written once to the scratchpad. `sp_we` pulses in the cycle after acceptance, with `sp_addr` set to the slot at the head of the free list. After reset, slots are handed out in the order 0, 1, 2 and so on.
- R3: The slot number of an accepted message is appended to the queue of every thread whose mask bit is set. Thread t is mask bit t. Threads whose bits are clear are not affected.
- R4: Once a message is accepted, `in_ready` stays low while fan-out is in progress. Fan-out takes at most 16 cycles, because each bank of 16 queues makes one enqueue per cycle.
- R5: If any selected thread already holds 4 entries, `in_ready` is low. Nothing is delivered to any thread and no slot is used.
- R6: If the free list is empty, `in_ready` is low for any nonzero mask.
- R7: A slot's reference count starts at the popcount of the mask. The slot returns to the tail of the free list only on the release that brings the count to zero.
- R8: A message whose mask is all zeros is accepted while the block is idle. It is dropped without using a slot or writing the scratchpad.
- R9: A receive request for thread t with a non-empty queue returns the oldest slot of that queue on `rx_resp_ptr`, with `rx_resp_valid`, in the next cycle. A request on an empty queue produces no response. `rx_empty[t]` shows the empty status of thread t.
- R10: A release that names a slot whose count is already zero is ignored.
- R11: In a cycle where a release names the slot at the head of the free list, `in_ready` is held low. This stops an allocation from colliding with a release on the same count entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message offered |
| in_ready | output | 1 | Message accepted this cycle when valid is also high |
| in_mask | input | 64 | Destination threads, bit t selects thread t |
| in_payload | input | 512 | Message payload, four 128-bit flits |
| sp_we | output | 1 | Scratchpad write strobe |
| sp_addr | output | 4 | Scratchpad slot written |
| sp_data | output | 512 | Payload written |
| rx_valid | input | 1 | Receive request |
| rx_thread | input | 6 | Thread issuing the receive request |
| rx_empty | output | 64 | Empty status per thread queue |
| rx_resp_valid | output | 1 | Receive response valid |
| rx_resp_ptr | output | 4 | Slot dequeued for the request |
| rel_valid | input | 1 | Release request |
| rel_slot | input | 4 | Slot being released |

## Verification
Several properties are checked by assertions on every cycle. The input is blocked while fan-out is in progress, and the busy run is never longer than one bank's queue count. Each scratchpad write is paired with an acceptance of a nonzero mask, and an all-zeros mask never causes a write. Receive responses follow exactly the requests made on non-empty queues. A nonzero mask is never accepted while the free list is empty. Other behaviour needs the bench's scenarios, which track the queues, free list and counts in a model: the order in which slots are reused after partial and complete releases, delivery to exactly the masked threads, the all-or-nothing stall when one queue is full, the release collision stall, and releases that are ignored.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DEF_THREADS = 64;
  localparam int DEF_BANKS   = 4;
  localparam int DEF_SLOTS   = 16;
  localparam int DEF_QDEPTH  = 4;
  localparam int DEF_FLIT_W  = 128;
  localparam int DEF_FLITS   = 4;
endpackage

// File: rtl/mbx_free_list.sv
module mbx_free_list #(
  parameter int SLOTS  = 16,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pop,
  input  logic              push,
  input  logic [SLOT_W-1:0] push_slot,
  output logic [SLOT_W-1:0] head,
  output logic              avail,
  output logic [SLOT_W:0]   cnt
);
  logic [SLOT_W-1:0] ring [SLOTS];
  logic [SLOT_W-1:0] rd_p, wr_p;

  assign head  = ring[rd_p];
  assign avail = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) ring[i] <= SLOT_W'(i);
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= (SLOT_W+1)'(SLOTS);
    end else begin
      if (push) begin
        ring[wr_p] <= push_slot;
        wr_p <= wr_p + 1'b1;
      end
      if (pop) rd_p <= rd_p + 1'b1;
      cnt <= cnt + (SLOT_W+1)'(push) - (SLOT_W+1)'(pop);
    end
  end
endmodule

// File: rtl/mbx_refcnt.sv
module mbx_refcnt #(
  parameter int SLOTS  = 16,
  parameter int SLOT_W = 4,
  parameter int RC_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic [RC_W-1:0]   set_val,
  input  logic              rel_en,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic              free_en,
  output logic [SLOT_W-1:0] free_slot
);
  logic [RC_W-1:0] count [SLOTS];
  logic            live;

  assign live      = (count[rel_slot] != '0);
  assign free_en   = rel_en && (count[rel_slot] == RC_W'(1));
  assign free_slot = rel_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) count[i] <= '0;
    end else begin
      if (rel_en && live) count[rel_slot] <= count[rel_slot] - 1'b1;
      if (set_en) count[set_slot] <= set_val;
    end
  end
endmodule

// File: rtl/mbx_qbank.sv
module mbx_qbank #(
  parameter int QPB    = 16,
  parameter int QDEPTH = 4,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [QPB-1:0]    load_mask,
  input  logic [SLOT_W-1:0] load_ptr,
  output logic              busy,
  input  logic              deq_en,
  input  logic [$clog2(QPB)-1:0] deq_q,
  output logic [SLOT_W-1:0] rd_ptr,
  output logic [QPB-1:0]    empty,
  output logic [QPB-1:0]    full
);
  localparam int QB_W = $clog2(QPB);
  localparam int D_W  = $clog2(QDEPTH);
  localparam int C_W  = $clog2(QDEPTH + 1);

  logic [QPB-1:0]    pend;
  logic [SLOT_W-1:0] ptr_r;
  logic [D_W-1:0]    head [QPB];
  logic [D_W-1:0]    tail [QPB];
  logic [C_W-1:0]    cnt  [QPB];
  logic [SLOT_W-1:0] mem  [QPB*QDEPTH];
  logic [QB_W-1:0]   pick;
  logic              wr_en, deq_fire;

  always_comb begin
    pick = '0;
    for (int i = QPB-1; i >= 0; i--) if (pend[i]) pick = QB_W'(i);
  end

  assign wr_en    = |pend;
  assign busy     = wr_en;
  assign deq_fire = deq_en && (cnt[deq_q] != '0);

  // queue data RAM: one write port, one registered read port, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[{pick, tail[pick]}] <= ptr_r;
    if (deq_fire) rd_ptr <= mem[{deq_q, head[deq_q]}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      ptr_r <= '0;
      for (int i = 0; i < QPB; i++) begin
        head[i] <= '0;
        tail[i] <= '0;
        cnt[i]  <= '0;
      end
    end else begin
      if (load) begin
        pend  <= load_mask;
        ptr_r <= load_ptr;
      end else if (wr_en) begin
        pend[pick] <= 1'b0;
      end
      if (wr_en) tail[pick] <= tail[pick] + 1'b1;
      if (deq_fire) head[deq_q] <= head[deq_q] + 1'b1;
      for (int i = 0; i < QPB; i++)
        cnt[i] <= cnt[i] + C_W'(wr_en && (pick == QB_W'(i)))
                         - C_W'(deq_fire && (deq_q == QB_W'(i)));
    end
  end

  for (genvar g = 0; g < QPB; g++) begin : g_stat
    assign empty[g] = (cnt[g] == '0);
    assign full[g]  = (cnt[g] == C_W'(QDEPTH));
  end
endmodule

// File: rtl/mbx_mcast_rx.sv
module mbx_mcast_rx #(
  parameter int THREADS = mbx_pkg::DEF_THREADS,
  parameter int BANKS   = mbx_pkg::DEF_BANKS,
  parameter int SLOTS   = mbx_pkg::DEF_SLOTS,
  parameter int QDEPTH  = mbx_pkg::DEF_QDEPTH,
  parameter int MSG_W   = mbx_pkg::DEF_FLIT_W * mbx_pkg::DEF_FLITS,
  localparam int TID_W  = $clog2(THREADS),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [THREADS-1:0] in_mask,
  input  logic [MSG_W-1:0]   in_payload,
  output logic               sp_we,
  output logic [SLOT_W-1:0]  sp_addr,
  output logic [MSG_W-1:0]   sp_data,
  input  logic               rx_valid,
  input  logic [TID_W-1:0]   rx_thread,
  output logic [THREADS-1:0] rx_empty,
  output logic               rx_resp_valid,
  output logic [SLOT_W-1:0]  rx_resp_ptr,
  input  logic               rel_valid,
  input  logic [SLOT_W-1:0]  rel_slot
);
  localparam int QPB  = THREADS / BANKS;
  localparam int QB_W = $clog2(QPB);
  localparam int BK_W = $clog2(BANKS);
  localparam int RC_W = $clog2(THREADS + 1);

  logic [BANKS-1:0]   bank_busy;
  logic [THREADS-1:0] q_full, q_empty;
  logic [SLOT_W-1:0]  bank_rd [BANKS];
  logic               fan_busy, mask_nz, sel_full, clash, take, deq_ok;
  logic               fl_avail, rc_free;
  logic [SLOT_W-1:0]  fl_head, rc_free_slot;
  logic [SLOT_W:0]    fl_cnt;
  logic [BK_W-1:0]    rx_bank, resp_bank;
  logic [QB_W-1:0]    rx_q;

  assign fan_busy = |bank_busy;
  assign mask_nz  = |in_mask;
  assign sel_full = |(in_mask & q_full);
  assign clash    = rel_valid && (rel_slot == fl_head);
  assign in_ready = !fan_busy && (!mask_nz || (fl_avail && !sel_full && !clash));
  assign take     = in_valid && in_ready && mask_nz;
  assign rx_bank  = rx_thread[TID_W-1:QB_W];
  assign rx_q     = rx_thread[QB_W-1:0];
  assign deq_ok   = rx_valid && !q_empty[rx_thread];
  assign rx_empty = q_empty;

  mbx_free_list #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_free (
    .clk(clk), .rst(rst), .pop(take), .push(rc_free), .push_slot(rc_free_slot),
    .head(fl_head), .avail(fl_avail), .cnt(fl_cnt)
  );

  mbx_refcnt #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .RC_W(RC_W)) u_rc (
    .clk(clk), .rst(rst), .set_en(take), .set_slot(fl_head),
    .set_val(RC_W'($countones(in_mask))), .rel_en(rel_valid), .rel_slot(rel_slot),
    .free_en(rc_free), .free_slot(rc_free_slot)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    mbx_qbank #(.QPB(QPB), .QDEPTH(QDEPTH), .SLOT_W(SLOT_W)) u_bank (
      .clk(clk), .rst(rst), .load(take), .load_mask(in_mask[b*QPB +: QPB]),
      .load_ptr(fl_head), .busy(bank_busy[b]),
      .deq_en(deq_ok && (rx_bank == BK_W'(b))), .deq_q(rx_q),
      .rd_ptr(bank_rd[b]), .empty(q_empty[b*QPB +: QPB]), .full(q_full[b*QPB +: QPB])
    );
  end

  assign rx_resp_ptr = bank_rd[resp_bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_we         <= 1'b0;
      sp_addr       <= '0;
      rx_resp_valid <= 1'b0;
      resp_bank     <= '0;
    end else begin
      sp_we         <= take;
      if (take) sp_addr <= fl_head;
      rx_resp_valid <= deq_ok;
      if (deq_ok) resp_bank <= rx_bank;
    end
  end

  always_ff @(posedge clk) begin
    if (take) sp_data <= in_payload;
  end
endmodule

// File: rtl/mbx_mcast_rx_chk.sv
module mbx_mcast_rx_chk #(
  parameter int THREADS = 64,
  parameter int QPB     = 16,
  parameter int SLOTS   = 16,
  parameter int TID_W   = 6,
  parameter int SLOT_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic [THREADS-1:0] in_mask,
  input logic               sp_we,
  input logic               rx_valid,
  input logic [TID_W-1:0]   rx_thread,
  input logic [THREADS-1:0] rx_empty,
  input logic               rx_resp_valid,
  input logic               fan_busy,
  input logic [SLOT_W:0]    free_cnt
);
  logic [$clog2(QPB)+1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= '0;
    else if (fan_busy) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;
  end

  assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    fan_busy |-> !in_ready);
  assert_fanout_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy_run <= ($clog2(QPB)+2)'(QPB));
  assert_write_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (|in_mask)) |=> sp_we);
  assert_no_spurious_write_R2: assert property (@(posedge clk) disable iff (rst)
    sp_we |-> $past(in_valid && in_ready && (|in_mask)));
  assert_zero_mask_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !(|in_mask)) |=> !sp_we);
  assert_resp_on_data_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_empty[rx_thread]) |=> rx_resp_valid);
  assert_resp_origin_R9: assert property (@(posedge clk) disable iff (rst)
    rx_resp_valid |-> $past(rx_valid && !rx_empty[rx_thread]));
  assert_no_slot_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (in_ready && (|in_mask)) |-> (free_cnt != '0));
  assert_free_bound_R7: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= (SLOT_W+1)'(SLOTS));
endmodule

bind mbx_mcast_rx mbx_mcast_rx_chk #(
  .THREADS(THREADS), .QPB(QPB), .SLOTS(SLOTS), .TID_W(TID_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_mask(in_mask),
  .sp_we(sp_we), .rx_valid(rx_valid), .rx_thread(rx_thread), .rx_empty(rx_empty),
  .rx_resp_valid(rx_resp_valid), .fan_busy(fan_busy), .free_cnt(fl_cnt)
);

// File: tb/test_mbx_mcast_rx.sv
module test_mbx_mcast_rx;
  localparam int CLK_PERIOD = 10;
  localparam int THREADS = 64;
  localparam int SLOTS   = 16;
  localparam int QDEPTH  = 4;
  localparam int MSG_W   = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [THREADS-1:0] in_mask = '0;
  logic [MSG_W-1:0] in_payload = '0;
  logic sp_we;
  logic [3:0] sp_addr;
  logic [MSG_W-1:0] sp_data;
  logic rx_valid = 1'b0;
  logic [5:0] rx_thread = '0;
  logic [THREADS-1:0] rx_empty;
  logic rx_resp_valid;
  logic [3:0] rx_resp_ptr;
  logic rel_valid = 1'b0;
  logic [3:0] rel_slot = '0;

  int n_vec = 0;
  int n_bad = 0;
  int mq [THREADS][$];
  int mfree [$];
  int mrc [SLOTS];
  int held [$];

  mbx_mcast_rx i_mbx_mcast_rx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_mask(in_mask),
    .in_payload(in_payload), .sp_we(sp_we), .sp_addr(sp_addr), .sp_data(sp_data),
    .rx_valid(rx_valid), .rx_thread(rx_thread), .rx_empty(rx_empty),
    .rx_resp_valid(rx_resp_valid), .rx_resp_ptr(rx_resp_ptr),
    .rel_valid(rel_valid), .rel_slot(rel_slot)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [THREADS-1:0] exp_empty();
    logic [THREADS-1:0] e;
    for (int t = 0; t < THREADS; t++) e[t] = (mq[t].size() == 0);
    return e;
  endfunction

  function automatic logic [MSG_W-1:0] rnd_payload();
    logic [MSG_W-1:0] p;
    for (int i = 0; i < MSG_W/32; i++) p[i*32 +: 32] = $urandom;
    return p;
  endfunction

  task automatic send(logic [THREADS-1:0] m, logic [MSG_W-1:0] p);
    bit sel_full = 0;
    bit exp_rdy;
    int slot;
    string why;
    for (int t = 0; t < THREADS; t++) if (m[t] && mq[t].size() == QDEPTH) sel_full = 1;
    exp_rdy = (m == '0) || (mfree.size() != 0 && !sel_full);
    why = (m == '0) ? "R8" : (mfree.size() == 0) ? "R6" : sel_full ? "R5" : "R2";
    @(negedge clk);
    in_valid = 1'b1; in_mask = m; in_payload = p;
    #1 chk(in_ready == exp_rdy, why, 64'(in_ready), 64'(exp_rdy));
    @(negedge clk);
    in_valid = 1'b0; in_mask = '0;
    #1;
    if (exp_rdy && m != '0) begin
      slot = mfree.pop_front();
      chk(sp_we == 1'b1, "R2", 64'(sp_we), 64'd1);
      chk(sp_addr == slot[3:0], "R2 R7 slot order", 64'(sp_addr), 64'(slot));
      chk(sp_data == p, "R2 payload", sp_data[63:0], p[63:0]);
      chk(in_ready == 1'b0, "R4 busy", 64'(in_ready), 64'd0);
      mrc[slot] = $countones(m);
      for (int t = 0; t < THREADS; t++) if (m[t]) mq[t].push_back(slot);
    end else begin
      chk(sp_we == 1'b0, (m == '0) ? "R8" : "R5 R6 no write", 64'(sp_we), 64'd0);
    end
    repeat (16) @(negedge clk);
    #1 chk(in_ready == 1'b1, "R4 done", 64'(in_ready), 64'd1);
    chk(rx_empty == exp_empty(), "R3", rx_empty, exp_empty());
  endtask

  task automatic recv(int t);
    bit e;
    int slot;
    e = (mq[t].size() == 0);
    @(negedge clk);
    rx_valid = 1'b1; rx_thread = 6'(t);
    #1 chk(rx_empty[t] == e, "R9 empty", 64'(rx_empty[t]), 64'(e));
    @(negedge clk);
    rx_valid = 1'b0;
    #1;
    if (!e) begin
      slot = mq[t].pop_front();
      chk(rx_resp_valid == 1'b1, "R9 valid", 64'(rx_resp_valid), 64'd1);
      chk(rx_resp_ptr == slot[3:0], "R9 ptr", 64'(rx_resp_ptr), 64'(slot));
      held.push_back(slot);
    end else begin
      chk(rx_resp_valid == 1'b0, "R9 no resp", 64'(rx_resp_valid), 64'd0);
    end
  endtask

  task automatic release_slot(int s);
    @(negedge clk);
    rel_valid = 1'b1; rel_slot = 4'(s);
    @(negedge clk);
    rel_valid = 1'b0;
    if (mrc[s] > 0) begin
      mrc[s]--;
      if (mrc[s] == 0) mfree.push_back(s);
    end
  endtask

  task automatic release_all();
    while (held.size() != 0) release_slot(held.pop_front());
  endtask

  task automatic clash_check();
    if (mfree.size() == 0) return;
    @(negedge clk);
    in_valid = 1'b1; in_mask = 64'h1; rel_valid = 1'b1; rel_slot = 4'(mfree[0]);
    #1 chk(in_ready == 1'b0, "R11", 64'(in_ready), 64'd0);
    in_valid = 1'b0; in_mask = '0;
    @(negedge clk);
    rel_valid = 1'b0;
    #1 chk(sp_we == 1'b0, "R11 no write", 64'(sp_we), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < SLOTS; s++) begin mfree.push_back(s); mrc[s] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R1 ready", 64'(in_ready), 64'd1);
    chk(rx_empty == '1, "R1 empty", rx_empty, '1);
    chk(sp_we == 1'b0, "R1 sp_we", 64'(sp_we), 64'd0);
    chk(rx_resp_valid == 1'b0, "R1 resp", 64'(rx_resp_valid), 64'd0);

    // R10: release of an unused slot changes nothing (seen later via slot order)
    release_slot(5);
    clash_check();
    send('0, rnd_payload());
    recv(9);

    // R6: exhaust all slots
    for (int i = 0; i < SLOTS; i++) send(64'd1 << i, rnd_payload());
    send(64'd1 << 20, rnd_payload());
    for (int i = 0; i < SLOTS; i++) recv(i);
    release_all();

    // full fan-out to every thread, R7 partial releases keep slot busy
    send('1, rnd_payload());
    for (int t = 0; t < THREADS; t++) recv(t);
    release_all();

    // R5: thread 7 full, mask 7|40 stalls and thread 40 stays empty
    for (int i = 0; i < QDEPTH; i++) send(64'd1 << 7, rnd_payload());
    send((64'd1 << 7) | (64'd1 << 40), rnd_payload());
    chk(rx_empty[40] == 1'b1, "R5 no partial", 64'(rx_empty[40]), 64'd1);
    for (int i = 0; i < QDEPTH; i++) recv(7);
    release_all();

    for (int it = 0; it < 700; it++) begin
      int r;
      r = $urandom % 8;
      if (r < 3) begin
        logic [THREADS-1:0] m;
        m = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        if ($urandom % 10 == 0) m = '0;
        send(m, rnd_payload());
      end else if (r < 6) begin
        recv($urandom % THREADS);
      end else if (r < 7 && held.size() != 0) begin
        int k;
        int s;
        k = $urandom % held.size();
        s = held[k];
        held.delete(k);
        release_slot(s);
      end else if ($urandom % 4 == 0) begin
        clash_check();
      end else begin
        release_slot($urandom % SLOTS);
      end
    end
    for (int t = 0; t < THREADS; t++) while (mq[t].size() != 0) recv(t);
    release_all();
    send(64'h8000_0000_0000_0001, rnd_payload());

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule